// File: doc/BRIEF.md
# EX-Stage Operand Bypass Selector

This block decides, for each of the two ALU operands in the execute stage of a five-stage in-order integer pipeline, where that operand's value should come from. It compares the two source register numbers of the instruction now in execute against the destination register numbers of the two older instructions still in flight. One older instruction has just left execute and the other is about to write back. For each operand it produces a 2-bit select that steers the operand multiplexer outside this block.

A producer is only a candidate if it will actually write a register, and if that register is not the hardwired zero register. When both in-flight instructions target the same register, the younger one (just out of execute) holds the newer value and wins. The two operands are resolved separately. A global enable forces both selects to the register-file path.

The decision is purely combinational, so the selects follow the inputs within the same cycle. A clock and an active-low reset feed only the built-in temporal checks and never gate the outputs.

Top module: `bypass_select_unit`

## Requirements
- R1: Each select uses these codes: 2'b00 takes the register-file value, 2'b10 takes the result of the instruction just past execute (near stage), and 2'b01 takes the result of the instruction at write-back (far stage). The code 2'b11 never appears.
- R2: Operand A selects 2'b10 when the near-stage write enable is 1, the near-stage destination is non-zero, and it equals `src_a`. Operand B follows the same rule with `src_b`.
- R3: A destination of register 0 is never bypassed from either stage, whatever the write enables are.
- R4: An operand selects 2'b01 when the far-stage write enable is 1, the far-stage destination is non-zero and equals that operand's source, and the near-stage rule of R2 does not hold for that operand.
- R5: When both stages qualify for the same operand, the select is 2'b10. This holds through a chain of consecutive writes to one register.
- R6: Operand A depends only on `src_a` and operand B only on `src_b`. Equal sources give equal selects.
- R7: While `enable` is 0, both selects are 2'b00.
- R8: The selects change in the same cycle as the inputs, with no register stage between them.
- R9: A stage whose write enable is 0 is ignored even when its destination matches. A matching far stage then still bypasses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the built-in checks only |
| rst_n | input | 1 | Active-low reset that disables the built-in checks |
| enable | input | 1 | Global bypass enable; 0 forces both selects to 2'b00 |
| src_a | input | REG_W | Source register number for ALU operand A |
| src_b | input | REG_W | Source register number for ALU operand B |
| near_dst | input | REG_W | Destination register of the instruction just past execute |
| near_wr | input | 1 | Register-write enable of that instruction |
| far_dst | input | REG_W | Destination register of the instruction at write-back |
| far_wr | input | 1 | Register-write enable of that instruction |
| sel_a | output | 2 | Operand A source select |
| sel_b | output | 2 | Operand B source select |

## Verification
The block holds no state, so any fault in the match or priority logic shows on `sel_a` or `sel_b` in the same cycle as the input pattern that exposes it. Nothing is hidden for later cycles. A priority fault only shows when both stages name the same register, and a zero-register fault only shows when a write to register 0 is pending, so the directed tasks build exactly those patterns. A bounded sweep over register numbers including 0 and the top index then covers the rest.

// File: rtl/bypass_pkg.sv
`timescale 1ns/1ps
package bypass_pkg;
   typedef enum logic [1:0] {
      SRC_REGFILE = 2'b00,
      SRC_FAR     = 2'b01,
      SRC_NEAR    = 2'b10
   } bypass_src_e;
endpackage

// File: rtl/bypass_match.sv
`timescale 1ns/1ps
module bypass_match #(
   parameter int REG_W     = 5,
   parameter bit ZERO_SINK = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] dst,
   input  logic             wr,
   output logic             hit
);
   localparam logic [REG_W-1:0] ZERO_IDX = '0;

   generate
      if (ZERO_SINK) begin : g_sink
         always_comb hit = wr && (dst != ZERO_IDX) && (dst == src);
      end else begin : g_plain
         always_comb hit = wr && (dst == src);
      end
   endgenerate
endmodule

// File: rtl/bypass_operand.sv
`timescale 1ns/1ps
module bypass_operand
   import bypass_pkg::*;
#(
   parameter int REG_W     = 5,
   parameter bit ZERO_SINK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] near_dst,
   input  logic             near_wr,
   input  logic [REG_W-1:0] far_dst,
   input  logic             far_wr,
   output bypass_src_e      sel
);
   localparam logic [REG_W-1:0] ZERO_IDX = '0;

   logic near_hit;
   logic far_hit;

   bypass_match #(.REG_W(REG_W), .ZERO_SINK(ZERO_SINK)) u_near (
      .src(src), .dst(near_dst), .wr(near_wr), .hit(near_hit)
   );

   bypass_match #(.REG_W(REG_W), .ZERO_SINK(ZERO_SINK)) u_far (
      .src(src), .dst(far_dst), .wr(far_wr), .hit(far_hit)
   );

   always_comb begin
      sel = SRC_REGFILE;
      if (en) begin
         if (near_hit)     sel = SRC_NEAR;
         else if (far_hit) sel = SRC_FAR;
      end
   end

   assert_code_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sel != 2'b11);

   assert_near_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && near_wr && near_dst != ZERO_IDX && near_dst == src) |-> sel == SRC_NEAR);

   assert_enable_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> sel == SRC_REGFILE);

   assert_wr_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!near_wr && !far_wr) |-> sel == SRC_REGFILE);

   generate
      if (ZERO_SINK) begin : g_zero_chk
         assert_zero_dst_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (near_dst == ZERO_IDX && far_dst == ZERO_IDX) |-> sel == SRC_REGFILE);
      end
   endgenerate
endmodule

// File: rtl/bypass_select_unit.sv
`timescale 1ns/1ps
module bypass_select_unit
   import bypass_pkg::*;
#(
   parameter int REG_W     = 5,
   parameter bit ZERO_SINK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [REG_W-1:0] src_a,
   input  logic [REG_W-1:0] src_b,
   input  logic [REG_W-1:0] near_dst,
   input  logic             near_wr,
   input  logic [REG_W-1:0] far_dst,
   input  logic             far_wr,
   output logic [1:0]       sel_a,
   output logic [1:0]       sel_b
);
   localparam int N_OPND = 2;

   generate
      if (REG_W < 1 || REG_W > 16) begin : g_bad_width
         $error("bypass_select_unit: REG_W must lie in 1..16");
      end
   endgenerate

   logic [REG_W-1:0] src_vec [N_OPND];
   bypass_src_e      sel_vec [N_OPND];

   always_comb begin
      src_vec[0] = src_a;
      src_vec[1] = src_b;
   end

   generate
      for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
         bypass_operand #(.REG_W(REG_W), .ZERO_SINK(ZERO_SINK)) u_opnd (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (enable),
            .src      (src_vec[k]),
            .near_dst (near_dst),
            .near_wr  (near_wr),
            .far_dst  (far_dst),
            .far_wr   (far_wr),
            .sel      (sel_vec[k])
         );
      end
   endgenerate

   assign sel_a = sel_vec[0];
   assign sel_b = sel_vec[1];

   assert_same_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (src_a == src_b) |-> (sel_a == sel_b));

   assert_no_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $stable({enable, src_a, src_b, near_dst, near_wr, far_dst, far_wr})
      |-> $stable({sel_a, sel_b}));
endmodule

// File: tb/bypass_select_unit_test.sv
`timescale 1ns/1ps
module bypass_select_unit_test;
   localparam int RW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic [RW-1:0] src_a = '0, src_b = '0, near_dst = '0, far_dst = '0;
   logic          near_wr = 1'b0, far_wr = 1'b0;
   logic [1:0]    sel_a, sel_b;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   bypass_select_unit #(.REG_W(RW)) uut (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .src_a(src_a), .src_b(src_b),
      .near_dst(near_dst), .near_wr(near_wr),
      .far_dst(far_dst), .far_wr(far_wr),
      .sel_a(sel_a), .sel_b(sel_b)
   );

   function automatic logic [1:0] model(input logic [RW-1:0] s, input logic en,
                                        input logic [RW-1:0] nd, input logic nw,
                                        input logic [RW-1:0] fd, input logic fw);
      if (!en) return 2'b00;
      if (nw && nd != 0 && nd == s) return 2'b10;
      if (fw && fd != 0 && fd == s) return 2'b01;
      return 2'b00;
   endfunction

   task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic apply(input logic en, input logic [RW-1:0] a, input logic [RW-1:0] b,
                        input logic [RW-1:0] nd, input logic nw,
                        input logic [RW-1:0] fd, input logic fw);
      @(negedge clk);
      enable = en; src_a = a; src_b = b;
      near_dst = nd; near_wr = nw; far_dst = fd; far_wr = fw;
      #1;
   endtask

   task automatic t_reset;
      check("R1 reset A", sel_a, 2'b00);
      check("R1 reset B", sel_b, 2'b00);
   endtask

   task automatic t_near;
      apply(1, 5'd2, 5'd7, 5'd2, 1, 5'd0, 0);
      check("R2 near to A", sel_a, 2'b10);
      check("R2 B untouched", sel_b, 2'b00);
      apply(1, 5'd9, 5'd2, 5'd2, 1, 5'd0, 0);
      check("R2 near to B", sel_b, 2'b10);
      check("R2 A untouched", sel_a, 2'b00);
   endtask

   task automatic t_far;
      apply(1, 5'd4, 5'd8, 5'd3, 1, 5'd4, 1);
      check("R4 far to A", sel_a, 2'b01);
      check("R4 B rf", sel_b, 2'b00);
      apply(1, 5'd4, 5'd31, 5'd3, 1, 5'd31, 1);
      check("R4 far to B top index", sel_b, 2'b01);
   endtask

   task automatic t_zero;
      apply(1, 5'd0, 5'd0, 5'd0, 1, 5'd0, 1);
      check("R3 zero A", sel_a, 2'b00);
      check("R3 zero B", sel_b, 2'b00);
      apply(1, 5'd0, 5'd0, 5'd0, 1, 5'd6, 1);
      check("R3 zero near falls to rf", sel_a, 2'b00);
   endtask

   task automatic t_chain;
      apply(1, 5'd1, 5'd2, 5'd1, 1, 5'd9, 1);
      check("R5 chain step1 A", sel_a, 2'b10);
      apply(1, 5'd1, 5'd3, 5'd1, 1, 5'd1, 1);
      check("R5 chain step2 A", sel_a, 2'b10);
      check("R5 chain step2 B", sel_b, 2'b00);
      apply(1, 5'd1, 5'd1, 5'd1, 1, 5'd1, 1);
      check("R5 both A", sel_a, 2'b10);
      check("R5 both B", sel_b, 2'b10);
   endtask

   task automatic t_indep;
      apply(1, 5'd5, 5'd6, 5'd5, 1, 5'd6, 1);
      check("R6 A near", sel_a, 2'b10);
      check("R6 B far", sel_b, 2'b01);
      apply(1, 5'd6, 5'd5, 5'd5, 1, 5'd6, 1);
      check("R6 A far", sel_a, 2'b01);
      check("R6 B near", sel_b, 2'b10);
   endtask

   task automatic t_enable;
      apply(0, 5'd5, 5'd6, 5'd5, 1, 5'd6, 1);
      check("R7 off A", sel_a, 2'b00);
      check("R7 off B", sel_b, 2'b00);
   endtask

   task automatic t_latency;
      apply(1, 5'd12, 5'd13, 5'd12, 1, 5'd13, 1);
      check("R8 same cycle A", sel_a, 2'b10);
      check("R8 same cycle B", sel_b, 2'b01);
      apply(1, 5'd12, 5'd13, 5'd0, 0, 5'd0, 0);
      check("R8 same cycle drop A", sel_a, 2'b00);
   endtask

   task automatic t_wgate;
      apply(1, 5'd3, 5'd3, 5'd3, 0, 5'd3, 1);
      check("R9 near off far wins A", sel_a, 2'b01);
      apply(1, 5'd3, 5'd3, 5'd3, 0, 5'd3, 0);
      check("R9 both off", sel_b, 2'b00);
   endtask

   task automatic t_sweep;
      logic [RW-1:0] pick [4];
      pick[0] = 5'd0; pick[1] = 5'd1; pick[2] = 5'd2; pick[3] = 5'd31;
      for (int a = 0; a < 4; a++)
         for (int n = 0; n < 4; n++)
            for (int f = 0; f < 4; f++)
               for (int w = 0; w < 8; w++) begin
                  apply(w[2], pick[a], pick[(a + 1) % 4], pick[n], w[0], pick[f], w[1]);
                  check("R2/R4 sweep A", sel_a,
                        model(pick[a], w[2], pick[n], w[0], pick[f], w[1]));
                  check("R6 sweep B", sel_b,
                        model(pick[(a + 1) % 4], w[2], pick[n], w[0], pick[f], w[1]));
               end
   endtask

   initial begin
      #1;
      t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_near();
      t_far();
      t_zero();
      t_chain();
      t_indep();
      t_enable();
      t_latency();
      t_wgate();
      t_sweep();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule